// File: doc/BRIEF.md
# Bus-Master Channel Register Set

This block holds the software-visible registers of one bus-master DMA channel: a command byte, a status byte and a 32-bit pointer to the descriptor table in memory. Software reaches them through a byte-addressed register port that supports byte, half-word and word accesses. The block turns command writes into one-cycle control pulses for a separate descriptor walker. A rising start bit reloads the walker's current descriptor pointer from the table pointer and kicks the walker. A falling start bit cancels the transfer.

The status byte tracks whether the channel is active, whether the walker ran off the end of its table, and whether the drive has raised its interrupt. The drive interrupt passes straight through to the host interrupt line. Its rising edge is also latched into status, and the latched bit stays set until software clears it. All control and status pins are plain levels or single-cycle pulses. The block has no streaming data path, so no valid/ready handshake applies.

Register selection on `reg_sel`: 0 is command, 1 is status, 2 is the table pointer, and 3 reads as zero and ignores writes. Access size on `reg_size`: 0 is byte, 1 is half-word, 2 or 3 is word. `reg_off` is the byte offset and matters only for the table pointer. Command and status reads return their byte in bits 7:0, with zeros above.

Top module: `bm_chan_regs`

## Requirements
- R1: A command write keeps only bit 0 (start) and bit 3 (direction, driven on `walk_to_mem`) and stores zero in every other bit; a command read returns the stored byte.
- R2: A command write that takes the start bit from 0 to 1 pulses `walk_reload` for exactly one cycle, in the cycle after the write. While the pulse is high, `walk_base` holds the table pointer.
- R3: On that same 0-to-1 start edge, if the active bit (status bit 0) was clear, the active bit becomes set and `walk_kick` pulses for one cycle alongside `walk_reload`.
- R4: A command write that takes the start bit from 1 to 0 pulses `walk_cancel` for one cycle and clears the active bit.
- R5: A command write that leaves the start bit unchanged produces no `walk_reload`, `walk_kick` or `walk_cancel` pulse.
- R6: A table pointer write updates only the byte lanes selected by size and offset, with the data shifted up by the offset. Bits 1:0 of the pointer are always zero.
- R7: A table pointer read returns the pointer shifted down by offset×8 bits, masked to the access width.
- R8: `host_irq` equals `dev_irq` at all times. A rising edge of `dev_irq` sets status bit 2, which stays set after `dev_irq` falls.
- R9: Writing 1 to status bit 1 or bit 2 clears that bit. Writes to status bit 0 have no effect.
- R10: A `walk_done` pulse clears the active bit. If `walk_exhausted` is high with it, status bit 1 (error) becomes set.
- R11: Reset clears the command byte, the status byte and the table pointer, and holds all walker pulses low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 command, 1 status, 2 table pointer) |
| reg_off | input | 2 | Byte offset within the table pointer |
| reg_size | input | 2 | Access size (0 byte, 1 half, 2/3 word) |
| reg_wdata | input | 32 | Write data, least significant lane first |
| reg_rdata | output | 32 | Combinational read data for the current select |
| walk_reload | output | 1 | Pulse: reload walker descriptor pointer |
| walk_kick | output | 1 | Pulse: walker begins transferring |
| walk_cancel | output | 1 | Pulse: walker abandons the transfer |
| walk_base | output | 32 | Descriptor table pointer |
| walk_to_mem | output | 1 | Direction bit from the command byte |
| walk_done | input | 1 | Pulse: walker finished |
| walk_exhausted | input | 1 | Qualifies `walk_done`: table ran out |
| dev_irq | input | 1 | Drive interrupt level |
| host_irq | output | 1 | Interrupt toward the host |

## Verification
Several properties are checked on every cycle by assertions. A kick or cancel pulse only follows a matching change of the stored start bit, and a steady start bit never produces a pulse. A cancel leaves the channel inactive. Unselected pointer lanes hold their value across a write. An interrupt edge or an exhausted completion always leaves its status bit set one cycle later. Only the bench's scenarios can show the exact stored values: command masking, lane placement and read shifting of the pointer, write-one-to-clear behaviour, the sequence of start, stop and completion, and the state after reset.

// File: rtl/bm_regs_pkg.sv
package bm_regs_pkg;
  localparam int BM_LANES = 4;
  localparam int BM_AW    = BM_LANES * 8;
  localparam int BM_OFF_W = $clog2(BM_LANES);
  localparam int BM_ALIGN = 2;

  localparam logic [7:0] CMD_KEEP_MASK = 8'h09;
  localparam int CMD_START_BIT = 0;
  localparam int CMD_DIR_BIT   = 3;

  localparam int ST_ACTIVE = 0;
  localparam int ST_ERROR  = 1;
  localparam int ST_IRQ    = 2;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_STAT = 2'd1,
    SEL_BASE = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;
endpackage

// File: rtl/bm_cmd_ctrl.sv
module bm_cmd_ctrl
  import bm_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_cmd,
  input  logic [7:0] wdata,
  input  logic       active,
  output logic [7:0] cmd_q,
  output logic       start_set,
  output logic       stop_clr,
  output logic       reload_q,
  output logic       kick_q,
  output logic       cancel_q
);
  logic rise, fall;

  always_comb begin
    rise      = wr_cmd &&  wdata[CMD_START_BIT] && !cmd_q[CMD_START_BIT];
    fall      = wr_cmd && !wdata[CMD_START_BIT] &&  cmd_q[CMD_START_BIT];
    start_set = rise && !active;
    stop_clr  = fall;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q    <= '0;
      reload_q <= 1'b0;
      kick_q   <= 1'b0;
      cancel_q <= 1'b0;
    end else begin
      if (wr_cmd) cmd_q <= wdata & CMD_KEEP_MASK;
      reload_q <= rise;
      kick_q   <= start_set;
      cancel_q <= fall;
    end
  end

  assert_kick_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    kick_q |-> (cmd_q[CMD_START_BIT] && !$past(cmd_q[CMD_START_BIT])))
    else $error("kick without start edge");

  assert_cancel_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_q |-> (!cmd_q[CMD_START_BIT] && $past(cmd_q[CMD_START_BIT])))
    else $error("cancel without stop edge");

  assert_no_pulse_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cmd_q[CMD_START_BIT]) |-> (!reload_q && !kick_q && !cancel_q))
    else $error("pulse while start bit steady");
endmodule

// File: rtl/bm_status_reg.sv
module bm_status_reg
  import bm_regs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_stat,
  input  logic [2:1] w1c,
  input  logic       start_set,
  input  logic       stop_clr,
  input  logic       walk_done,
  input  logic       walk_exhausted,
  input  logic       dev_irq,
  output logic [7:0] stat_byte
);
  logic act_q, err_q, irq_q, irq_prev_q;
  logic irq_rise;

  assign irq_rise  = dev_irq && !irq_prev_q;
  assign stat_byte = {5'b0, irq_q, err_q, act_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q      <= 1'b0;
      err_q      <= 1'b0;
      irq_q      <= 1'b0;
      irq_prev_q <= 1'b0;
    end else begin
      irq_prev_q <= dev_irq;
      if (start_set)                   act_q <= 1'b1;
      else if (stop_clr || walk_done)  act_q <= 1'b0;
      if (walk_done && walk_exhausted) err_q <= 1'b1;
      else if (wr_stat && w1c[ST_ERROR]) err_q <= 1'b0;
      if (irq_rise)                    irq_q <= 1'b1;
      else if (wr_stat && w1c[ST_IRQ]) irq_q <= 1'b0;
    end
  end

  assert_active_ro_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !start_set && !stop_clr && !walk_done) |=> (act_q == $past(act_q)))
    else $error("status write moved active bit");
endmodule

// File: rtl/bm_base_ptr.sv
module bm_base_ptr
  import bm_regs_pkg::*;
#(
  parameter int LANES = BM_LANES,
  parameter int ALIGN = BM_ALIGN,
  localparam int AW   = LANES * 8,
  localparam int OW   = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_base,
  input  logic [OW-1:0] off,
  input  logic [1:0]    size,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] base_q,
  output logic [AW-1:0] rd_view
);
  localparam logic [AW-1:0] ALIGN_CLR = ~((AW)'((1 << ALIGN) - 1));

  logic [LANES-1:0]   fill;
  logic [2*LANES-1:0] fill_wide;
  logic [LANES-1:0]   lane_en;
  logic [AW-1:0]      wshift, rmask, nxt;
  logic [OW+2:0]      bitsh;

  always_comb begin
    unique case (acc_size_e'(size))
      SZ_BYTE: begin fill = LANES'(1); rmask = AW'(8'hFF);   end
      SZ_HALF: begin fill = LANES'(3); rmask = AW'(16'hFFFF); end
      default: begin fill = '1;        rmask = '1;            end
    endcase
    bitsh     = {off, 3'b000};
    fill_wide = {{LANES{1'b0}}, fill} << off;
    lane_en   = fill_wide[LANES-1:0];
    wshift    = wdata << bitsh;
    rd_view   = (base_q >> bitsh) & rmask;
  end

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign nxt[8*k +: 8] = lane_en[k] ? wshift[8*k +: 8] : base_q[8*k +: 8];

    assert_lane_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_base && !lane_en[k]) |=> $stable(base_q[8*k +: 8]))
      else $error("unselected lane changed");
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       base_q <= '0;
    else if (wr_base) base_q <= nxt & ALIGN_CLR;
  end
endmodule

// File: rtl/bm_chan_regs.sv
module bm_chan_regs
  import bm_regs_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr_en,
  input  logic [1:0]  reg_sel,
  input  logic [1:0]  reg_off,
  input  logic [1:0]  reg_size,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        walk_reload,
  output logic        walk_kick,
  output logic        walk_cancel,
  output logic [31:0] walk_base,
  output logic        walk_to_mem,
  input  logic        walk_done,
  input  logic        walk_exhausted,
  input  logic        dev_irq,
  output logic        host_irq
);
  logic       wr_cmd, wr_stat, wr_base;
  logic [7:0] cmd_q, stat_byte;
  logic       start_set, stop_clr;
  logic [BM_AW-1:0] base_q, base_rd;

  assign wr_cmd  = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_CMD);
  assign wr_stat = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_STAT);
  assign wr_base = reg_wr_en && (reg_sel_e'(reg_sel) == SEL_BASE);

  bm_cmd_ctrl u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_cmd(wr_cmd), .wdata(reg_wdata[7:0]),
    .active(stat_byte[ST_ACTIVE]), .cmd_q(cmd_q), .start_set(start_set),
    .stop_clr(stop_clr), .reload_q(walk_reload), .kick_q(walk_kick),
    .cancel_q(walk_cancel)
  );

  bm_status_reg u_stat (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_stat), .w1c(reg_wdata[2:1]),
    .start_set(start_set), .stop_clr(stop_clr), .walk_done(walk_done),
    .walk_exhausted(walk_exhausted), .dev_irq(dev_irq), .stat_byte(stat_byte)
  );

  bm_base_ptr #(.LANES(BM_LANES), .ALIGN(BM_ALIGN)) u_base (
    .clk(clk), .rst_n(rst_n), .wr_base(wr_base), .off(reg_off),
    .size(reg_size), .wdata(reg_wdata), .base_q(base_q), .rd_view(base_rd)
  );

  assign walk_base   = base_q;
  assign walk_to_mem = cmd_q[CMD_DIR_BIT];
  assign host_irq    = dev_irq;

  always_comb begin
    unique case (reg_sel_e'(reg_sel))
      SEL_CMD:  reg_rdata = {24'b0, cmd_q};
      SEL_STAT: reg_rdata = {24'b0, stat_byte};
      SEL_BASE: reg_rdata = base_rd;
      default:  reg_rdata = '0;
    endcase
  end

  assert_cancel_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    walk_cancel |-> !stat_byte[ST_ACTIVE])
    else $error("cancel left channel active");

  assert_irq_latch_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dev_irq) |=> stat_byte[ST_IRQ])
    else $error("interrupt edge not latched");

  assert_exhaust_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_exhausted) |=> stat_byte[ST_ERROR])
    else $error("exhausted completion without error bit");

  assert_kick_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
    walk_kick |-> stat_byte[ST_ACTIVE])
    else $error("kick while channel inactive");
endmodule

// File: tb/bm_chan_regs_tb.sv
`timescale 1ns/1ps
module bm_chan_regs_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_sel = 2'd3, reg_off = 2'd0, reg_size = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        walk_reload, walk_kick, walk_cancel, walk_to_mem, host_irq;
  logic [31:0] walk_base;
  logic        walk_done = 1'b0, walk_exhausted = 1'b0, dev_irq = 1'b0;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  bm_chan_regs u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_off(reg_off), .reg_size(reg_size), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .walk_reload(walk_reload), .walk_kick(walk_kick),
    .walk_cancel(walk_cancel), .walk_base(walk_base), .walk_to_mem(walk_to_mem),
    .walk_done(walk_done), .walk_exhausted(walk_exhausted), .dev_irq(dev_irq),
    .host_irq(host_irq)
  );

  typedef struct packed {
    logic [1:0]  wsel;
    logic [1:0]  woff;
    logic [1:0]  wsize;
    logic [31:0] wdata;
    logic [1:0]  rsel;
    logic [1:0]  roff;
    logic [1:0]  rsize;
    logic [31:0] exp;
  } vec_t;

  // R6/R7 pointer lanes and R1 command masking; cmd writes keep start at 0 (R5)
  localparam vec_t VEC [8] = '{
    '{2'd2, 2'd0, 2'd2, 32'h12345677, 2'd2, 2'd0, 2'd2, 32'h12345674},
    '{2'd2, 2'd1, 2'd0, 32'h000000AB, 2'd2, 2'd0, 2'd2, 32'h1234AB74},
    '{2'd2, 2'd2, 2'd1, 32'h0000BEEF, 2'd2, 2'd2, 2'd1, 32'h0000BEEF},
    '{2'd2, 2'd0, 2'd0, 32'h000000FF, 2'd2, 2'd0, 2'd0, 32'h000000FC},
    '{2'd2, 2'd3, 2'd0, 32'h0000005A, 2'd2, 2'd3, 2'd0, 32'h0000005A},
    '{2'd0, 2'd0, 2'd0, 32'h000000F6, 2'd0, 2'd0, 2'd0, 32'h00000000},
    '{2'd0, 2'd0, 2'd0, 32'h00000008, 2'd0, 2'd0, 2'd0, 32'h00000008},
    '{2'd2, 2'd0, 2'd1, 32'h00000003, 2'd2, 2'd0, 2'd2, 32'h5AEF0000}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] size, input logic [31:0] data);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_off = off; reg_size = size; reg_wdata = data;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic rd(input logic [1:0] sel, input logic [1:0] off,
                    input logic [1:0] size, output logic [31:0] data);
    reg_sel = sel; reg_off = off; reg_size = size;
    #1 data = reg_rdata;
    reg_sel = 2'd3;
  endtask

  task automatic pulses(input string req, input logic [2:0] exp);
    check(req, {29'b0, walk_reload, walk_kick, walk_cancel}, {29'b0, exp});
  endtask

  task automatic done_pulse(input logic exh);
    @(negedge clk);
    walk_done = 1'b1; walk_exhausted = exh;
    @(negedge clk);
    walk_done = 1'b0; walk_exhausted = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rd(2'd0, 2'd0, 2'd0, d); check("R11 cmd", d, 32'h0);
    rd(2'd1, 2'd0, 2'd0, d); check("R11 status", d, 32'h0);
    rd(2'd2, 2'd0, 2'd2, d); check("R11 base", d, 32'h0);
    pulses("R11 pulses", 3'b000);
    check("R8 host_irq idle", {31'b0, host_irq}, 32'h0);

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i].wsel, VEC[i].woff, VEC[i].wsize, VEC[i].wdata);
      pulses("R5 table no pulse", 3'b000);
      rd(VEC[i].rsel, VEC[i].roff, VEC[i].rsize, d);
      check((VEC[i].wsel == 2'd0) ? "R1 table cmd" : "R6/R7 table base", d, VEC[i].exp);
    end
    check("R1 direction", {31'b0, walk_to_mem}, 32'h1);

    // R2 R3 start edge
    wr(2'd0, 2'd0, 2'd0, 32'h01);
    pulses("R2 R3 start pulses", 3'b110);
    check("R2 walk_base", walk_base, 32'h5AEF0000);
    rd(2'd1, 2'd0, 2'd0, d); check("R3 active set", d, 32'h01);
    check("R1 direction cleared", {31'b0, walk_to_mem}, 32'h0);
    @(negedge clk);
    pulses("R2 single cycle", 3'b000);

    // R5 steady start
    wr(2'd0, 2'd0, 2'd0, 32'hFF);
    pulses("R5 steady start", 3'b000);
    rd(2'd0, 2'd0, 2'd0, d); check("R1 cmd 0xFF masked", d, 32'h09);
    rd(2'd1, 2'd0, 2'd0, d); check("R5 still active", d, 32'h01);

    // R4 stop edge
    wr(2'd0, 2'd0, 2'd0, 32'h08);
    pulses("R4 cancel pulse", 3'b001);
    rd(2'd1, 2'd0, 2'd0, d); check("R4 active cleared", d, 32'h00);

    // R10 exhausted, R9 write-one-to-clear
    wr(2'd0, 2'd0, 2'd0, 32'h01);
    pulses("R3 restart kick", 3'b110);
    done_pulse(1'b1);
    rd(2'd1, 2'd0, 2'd0, d); check("R10 exhausted", d, 32'h02);
    wr(2'd1, 2'd0, 2'd0, 32'h01);
    rd(2'd1, 2'd0, 2'd0, d); check("R9 bit0 ignored", d, 32'h02);
    wr(2'd1, 2'd0, 2'd0, 32'h02);
    rd(2'd1, 2'd0, 2'd0, d); check("R9 error cleared", d, 32'h00);

    // R10 normal completion
    wr(2'd0, 2'd0, 2'd0, 32'h00);
    pulses("R4 cancel again", 3'b001);
    wr(2'd0, 2'd0, 2'd0, 32'h01);
    rd(2'd1, 2'd0, 2'd0, d); check("R3 active again", d, 32'h01);
    done_pulse(1'b0);
    rd(2'd1, 2'd0, 2'd0, d); check("R10 done clears active", d, 32'h00);

    // R8 interrupt
    @(negedge clk); dev_irq = 1'b1;
    #1 check("R8 host follows high", {31'b0, host_irq}, 32'h1);
    @(negedge clk);
    rd(2'd1, 2'd0, 2'd0, d); check("R8 irq latched", d, 32'h04);
    dev_irq = 1'b0;
    #1 check("R8 host follows low", {31'b0, host_irq}, 32'h0);
    @(negedge clk);
    rd(2'd1, 2'd0, 2'd0, d); check("R8 irq held", d, 32'h04);
    wr(2'd1, 2'd0, 2'd0, 32'h04);
    rd(2'd1, 2'd0, 2'd0, d); check("R9 irq cleared", d, 32'h00);

    // R11 reset while running
    wr(2'd0, 2'd0, 2'd0, 32'h00);
    wr(2'd0, 2'd0, 2'd0, 32'h09);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd(2'd0, 2'd0, 2'd0, d); check("R11 cmd after reset", d, 32'h0);
    rd(2'd1, 2'd0, 2'd0, d); check("R11 status after reset", d, 32'h0);
    rd(2'd2, 2'd0, 2'd2, d); check("R11 base after reset", d, 32'h0);
    pulses("R11 pulses after reset", 3'b000);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule